// File: doc/BRIEF.md
# Active reset sequencer

This block gathers every reset cause of a small microcontroller and turns it into one timed internal reset. The causes are power-on, a low-voltage alarm, a watchdog timeout, an illegal opcode, an illegal address and an external low on the shared reset pin. The reset pin is open-drain. The block reports a drive-low enable for it and reads the pin level back through a two-flop synchronizer, so that other chips on the board are reset together with the CPU.

A sequence first pulls the pin low for 32 oscillator cycles. The internal reset then stays high for another 32 cycles, and 3 more cycles allow for resynchronization. In the next cycle a single-cycle strobe tells the CPU to start its vector fetch. Power-on and low-voltage causes put a 4096-cycle stabilization window, with the pin held low, in front of this. The total is therefore 4163 cycles instead of 67.

A six-bit flag word records which causes were seen. Power-on acts asynchronously: it resets the block to a fresh long sequence and leaves only its own flag set. Other causes that arrive while a sequence runs do not change its timing, but their flags are still set. Software clears flags with a write-one-to-clear strobe.

Top module: `arst_ctrl`

## Requirements
- R1: While `por_req` is high, `int_rst` and `pin_drive_low` are 1, `vec_start` is 0 and `src_flags` equals 6'b000001.
- R2: A short cause (watchdog, illegal opcode, illegal address, external pin low) seen in idle holds `pin_drive_low` for exactly 32 cycles and `int_rst` for exactly 67 cycles.
- R3: A low-voltage cause seen in idle, or the release of `por_req`, holds `pin_drive_low` for 4128 cycles and `int_rst` for 4163 cycles. After release of `por_req`, the count includes the cycle in which it falls.
- R4: For `lvi_req`, `bad_op_req` and `bad_addr_req`, `int_rst` is high in the cycle after the clock edge that samples the request. For `wdog_req_async` and an external pin low, it is high three edges after the input changes, because of the two-flop synchronizers.
- R5: `vec_start` is high for exactly one cycle: the first cycle in which `int_rst` is low after a sequence.
- R6: `pin_drive_low` is high only while `int_rst` is high, and only at the start of the sequence. `int_rst` stays high for 35 cycles after the pin is released.
- R7: A non-power-on cause arriving during a running sequence does not change its length, but its flag is set.
- R8: Asserting `por_req` during a running sequence restarts a full long sequence and clears all flags except bit 0.
- R9: Flag bits are: 0 power-on, 1 low-voltage, 2 watchdog, 3 illegal opcode, 4 illegal address, 5 external pin. `clr_wr` clears the bits set in `clr_mask` at the next edge. A flag being set in the same cycle wins over the clear.
- R10: A pin low caused by the block's own drive, including its two-cycle synchronizer echo, is not recorded as a pin cause. `pin_level` follows the pin through two flops.
- R11: If a low-voltage cause and a short cause are seen in the same idle cycle, the long sequence runs and both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_req | input | 1 | Power-on pulse, asynchronous, active high |
| lvi_req | input | 1 | Low-voltage alarm, synchronous |
| wdog_req_async | input | 1 | Watchdog timeout, asynchronous |
| bad_op_req | input | 1 | Illegal opcode, synchronous |
| bad_addr_req | input | 1 | Illegal address, synchronous |
| pin_in | input | 1 | Level read from the reset pin |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 6 | Write-one-to-clear mask for the flags |
| pin_drive_low | output | 1 | Enable for the open-drain pull-down |
| pin_level | output | 1 | Synchronized pin level |
| int_rst | output | 1 | Internal reset to CPU and memories |
| vec_start | output | 1 | One-cycle vector-fetch start strobe |
| src_flags | output | 6 | Recorded reset causes |

## Verification
Some properties are checked on every cycle: the pin drive never appears without the internal reset, the drive never ends while the internal reset is low, the vector strobe is one cycle long and always follows reset, the drive-window counter stays in range, and a set flag wins over a simultaneous clear. Other behaviour only shows up over a whole scenario, so the bench scenarios cover it. This includes the exact lengths of the short and long windows, the latency through each synchronizer, the ignoring of causes in mid-sequence, a power-on restart with its flag wipe, and masking of the block's own pin echo. The bench mixes random causes, injections and gaps with directed cases.

// File: rtl/arst_pkg.sv
package arst_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LONG,
    S_DRIVE,
    S_HOLD,
    S_SYNC,
    S_REL
  } seq_state_e;

  localparam int NSRC     = 6;
  localparam int FLG_POR  = 0;
  localparam int FLG_LVI  = 1;
  localparam int FLG_WDOG = 2;
  localparam int FLG_OPC  = 3;
  localparam int FLG_ADR  = 4;
  localparam int FLG_PIN  = 5;
endpackage

// File: rtl/arst_sync2.sv
module arst_sync2 #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/arst_seq.sv
module arst_seq
  import arst_pkg::*;
#(
  parameter int LONG_CYC = 4096,
  parameter int PIN_CYC  = 32,
  parameter int INT_CYC  = 32,
  parameter int SYNC_CYC = 3
) (
  input  logic clk,
  input  logic por,
  input  logic long_req,
  input  logic short_req,
  output logic int_rst,
  output logic drive_low,
  output logic vec_start
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             at_end;

  always_comb begin
    case (state)
      S_LONG:  lim = CNT_W'(LONG_CYC - 1);
      S_DRIVE: lim = CNT_W'(PIN_CYC - 1);
      S_HOLD:  lim = CNT_W'(INT_CYC - 1);
      S_SYNC:  lim = CNT_W'(SYNC_CYC - 1);
      default: lim = '0;
    endcase
    at_end = (cnt == lim);
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      state <= S_LONG;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (long_req)       state <= S_LONG;
          else if (short_req) state <= S_DRIVE;
        end
        S_LONG, S_DRIVE, S_HOLD, S_SYNC: begin
          if (at_end) begin
            cnt <= '0;
            case (state)
              S_LONG:  state <= S_DRIVE;
              S_DRIVE: state <= S_HOLD;
              S_HOLD:  state <= S_SYNC;
              default: state <= S_REL;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign int_rst   = (state == S_LONG) || (state == S_DRIVE) ||
                     (state == S_HOLD) || (state == S_SYNC);
  assign drive_low = (state == S_LONG) || (state == S_DRIVE);
  assign vec_start = (state == S_REL);

  assert_drive_in_rst_R6: assert property (@(posedge clk) disable iff (por)
    drive_low |-> int_rst);
  assert_drive_end_held_R6: assert property (@(posedge clk) disable iff (por)
    $fell(drive_low) |-> int_rst);
  assert_vec_single_R5: assert property (@(posedge clk) disable iff (por)
    vec_start |=> !vec_start);
  assert_vec_after_rst_R5: assert property (@(posedge clk) disable iff (por)
    vec_start |-> $past(int_rst));
  assert_drive_cnt_range_R2: assert property (@(posedge clk) disable iff (por)
    (state == S_DRIVE) |-> (cnt < CNT_W'(PIN_CYC)));
endmodule

// File: rtl/arst_srclog.sv
module arst_srclog
  import arst_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] flags
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    localparam logic RST_V = (i == FLG_POR);
    always_ff @(posedge clk or posedge por) begin
      if (por) flags[i] <= RST_V;
      else     flags[i] <= set_vec[i] | (flags[i] & ~(clr_wr & clr_mask[i]));
    end
  end

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (por)
    (clr_wr && ((set_vec & clr_mask) != '0)) |=>
      ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/arst_ctrl.sv
module arst_ctrl
  import arst_pkg::*;
#(
  parameter int LONG_CYC = 4096,
  parameter int PIN_CYC  = 32,
  parameter int INT_CYC  = 32,
  parameter int SYNC_CYC = 3
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       lvi_req,
  input  logic       wdog_req_async,
  input  logic       bad_op_req,
  input  logic       bad_addr_req,
  input  logic       pin_in,
  input  logic       clr_wr,
  input  logic [5:0] clr_mask,
  output logic       pin_drive_low,
  output logic       pin_level,
  output logic       int_rst,
  output logic       vec_start,
  output logic [5:0] src_flags
);
  logic [1:0]      sync_q;
  logic            wdog_s;
  logic [1:0]      drv_hist;
  logic            own_low;
  logic            ext_low;
  logic            short_req;
  logic [NSRC-1:0] set_vec;

  arst_sync2 #(.W(2), .INIT(2'b10)) u_sync (
    .clk  (clk),
    .arst (por_req),
    .d    ({pin_in, wdog_req_async}),
    .q    (sync_q)
  );
  assign wdog_s    = sync_q[0];
  assign pin_level = sync_q[1];

  // Own drive echoes through the synchronizer for two edges after release.
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) drv_hist <= 2'b11;
    else         drv_hist <= {drv_hist[0], pin_drive_low};
  end
  assign own_low = pin_drive_low | (|drv_hist);
  assign ext_low = !pin_level && !own_low;

  assign short_req = wdog_s | bad_op_req | bad_addr_req | ext_low;

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_LVI]  = lvi_req;
    set_vec[FLG_WDOG] = wdog_s;
    set_vec[FLG_OPC]  = bad_op_req;
    set_vec[FLG_ADR]  = bad_addr_req;
    set_vec[FLG_PIN]  = ext_low;
  end

  arst_seq #(
    .LONG_CYC (LONG_CYC),
    .PIN_CYC  (PIN_CYC),
    .INT_CYC  (INT_CYC),
    .SYNC_CYC (SYNC_CYC)
  ) u_seq (
    .clk       (clk),
    .por       (por_req),
    .long_req  (lvi_req),
    .short_req (short_req),
    .int_rst   (int_rst),
    .drive_low (pin_drive_low),
    .vec_start (vec_start)
  );

  arst_srclog u_log (
    .clk      (clk),
    .por      (por_req),
    .set_vec  (set_vec),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .flags    (src_flags)
  );

  assert_no_self_pin_flag_R10: assert property (@(posedge clk) disable iff (por_req)
    pin_drive_low |=> (src_flags[FLG_PIN] == $past(src_flags[FLG_PIN]) ||
                       $past(clr_wr && clr_mask[FLG_PIN])));
endmodule

// File: tb/tb_arst_ctrl.sv
module tb_arst_ctrl;
  localparam int CLK_P = 10;
  localparam int LONG  = 4096;

  logic       clk = 0;
  logic       por_req, lvi_req, wdog_req_async, bad_op_req, bad_addr_req;
  logic       ext_low, clr_wr;
  logic [5:0] clr_mask;
  logic       pin_in, pin_drive_low, pin_level, int_rst, vec_start;
  logic [5:0] src_flags;
  logic [5:0] mflags;
  int         total = 0;
  int         bad   = 0;

  assign pin_in = !(pin_drive_low | ext_low);

  always #(CLK_P/2) clk = ~clk;

  arst_ctrl dut (
    .clk(clk), .por_req(por_req), .lvi_req(lvi_req), .wdog_req_async(wdog_req_async),
    .bad_op_req(bad_op_req), .bad_addr_req(bad_addr_req), .pin_in(pin_in),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .pin_drive_low(pin_drive_low),
    .pin_level(pin_level), .int_rst(int_rst), .vec_start(vec_start),
    .src_flags(src_flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cause codes: 1 lvi, 2 watchdog, 3 opcode, 4 address, 5 pin, 6 lvi+opcode
  function automatic logic [5:0] smask(input int s);
    case (s)
      1: return 6'b000010;
      2: return 6'b000100;
      3: return 6'b001000;
      4: return 6'b010000;
      5: return 6'b100000;
      6: return 6'b001010;
      default: return 6'b000000;
    endcase
  endfunction
  function automatic bit is_long(input int s);
    return (s == 1) || (s == 6);
  endfunction
  function automatic int exp_rlen(input int s);
    return is_long(s) ? LONG + 67 : 67;
  endfunction
  function automatic int exp_dlen(input int s);
    return is_long(s) ? LONG + 32 : 32;
  endfunction
  function automatic int exp_lat(input int s);
    return (s == 2 || s == 5) ? 3 : 1;
  endfunction

  task automatic drive_src(input int s, input logic v);
    case (s)
      1: lvi_req = v;
      2: wdog_req_async = v;
      3: bad_op_req = v;
      4: bad_addr_req = v;
      5: ext_low = v;
      6: begin lvi_req = v; bad_op_req = v; end
      default: ;
    endcase
  endtask

  task automatic body(input int rlen_e, input int dlen_e, input int inj, input int inj_at,
                      input string tag);
    int rc = 0;
    int dc = 0;
    bit dend = 0;
    bit order_ok = 1;
    bit pl_ok = 1;
    while (int_rst && rc < 5000) begin
      if (pin_drive_low) begin dc++; if (dend) order_ok = 0; end
      else dend = 1;
      if (rc == 5 && pin_level !== 1'b0) pl_ok = 0;
      if (inj > 0 && rc == inj_at) begin
        drive_src(inj, 1);
        if (inj != 5) mflags |= smask(inj);
      end else if (inj > 0 && rc == inj_at + 1) drive_src(inj, 0);
      rc++;
      @(negedge clk);
    end
    if (inj > 0) drive_src(inj, 0);
    chk(rc == rlen_e, {tag, " R7 reset length"}, rc, rlen_e);
    chk(dc == dlen_e, {tag, " pin drive length"}, dc, dlen_e);
    chk(order_ok, "R6 drive only at start", 0, 1);
    chk(rc - dc == 35, "R6 hold after pin release", rc - dc, 35);
    chk(pl_ok, "R10 pin_level follows drive", 1, 0);
    chk(vec_start === 1'b1, "R5 vector strobe", int'(vec_start), 1);
    @(negedge clk);
    chk(vec_start === 1'b0, "R5 strobe one cycle", int'(vec_start), 0);
    chk(pin_level === 1'b1, "R10 pin_level idle high", int'(pin_level), 1);
    chk(src_flags === mflags, "R9 flags", int'(src_flags), int'(mflags));
  endtask

  task automatic fire(input int s, input bit clr_all, input int inj, input int inj_at);
    int lat = 0;
    drive_src(s, 1);
    if (clr_all) begin clr_wr = 1; clr_mask = 6'h3f; mflags = '0; end
    mflags |= smask(s);
    do begin
      @(negedge clk);
      if (lat == 0) begin drive_src(s, 0); clr_wr = 0; end
      lat++;
    end while (!int_rst && lat < 20);
    chk(lat == exp_lat(s), "R4 start latency", lat, exp_lat(s));
    body(exp_rlen(s), exp_dlen(s), inj, inj_at, is_long(s) ? "R3" : "R2");
  endtask

  task automatic por_seq(input int hold, input string tag);
    por_req = 1;
    #1;
    mflags = 6'b000001;
    chk(int_rst === 1'b1, {tag, " R1 int_rst in por"}, int'(int_rst), 1);
    chk(pin_drive_low === 1'b1, "R1 drive in por", int'(pin_drive_low), 1);
    chk(vec_start === 1'b0, "R1 no strobe in por", int'(vec_start), 0);
    chk(src_flags === 6'b000001, {tag, " R1 flags in por"}, int'(src_flags), 1);
    repeat (hold) @(negedge clk);
    por_req = 0;
    body(LONG + 67, LONG + 32, -1, 0, "R3");
  endtask

  initial begin
    int unsigned seed;
    int longs = 0;
    por_req = 1; lvi_req = 0; wdog_req_async = 0; bad_op_req = 0; bad_addr_req = 0;
    ext_low = 0; clr_wr = 0; clr_mask = '0; mflags = 6'b000001;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    por_seq(3, "R1");

    fire(3, 0, -1, 0);
    fire(4, 0, -1, 0);
    fire(2, 0, -1, 0);
    fire(5, 0, -1, 0);
    fire(1, 0, -1, 0);
    fire(6, 0, -1, 0);                 // R11 lvi and opcode together
    chk(src_flags[1] && src_flags[3], "R11 both flags", int'(src_flags), 10);

    clr_wr = 1; clr_mask = 6'b010110;  // R9 partial clear
    @(negedge clk);
    clr_wr = 0;
    mflags &= ~6'b010110;
    chk(src_flags === mflags, "R9 partial clear", int'(src_flags), int'(mflags));

    fire(3, 1, -1, 0);                 // R9 set beats clear
    chk(src_flags === 6'b001000, "R9 set wins", int'(src_flags), 8);
    fire(4, 0, 3, 10);                 // R7 opcode injected mid-run
    fire(3, 0, 5, 4);                  // R10 pin pulse inside own drive
    fire(2, 0, 1, 8);                  // R7 lvi mid-run stays short

    // R8 power-on during a running short sequence
    bad_addr_req = 1;
    @(negedge clk);
    bad_addr_req = 0;
    repeat (10) @(negedge clk);
    chk(int_rst === 1'b1, "R8 running before por", int'(int_rst), 1);
    por_seq(2, "R8");

    for (int it = 0; it < 16; it++) begin
      int s = int'($urandom_range(6, 1));
      int inj = -1;
      int at = int'($urandom_range(20, 2));
      if (is_long(s)) begin
        if (longs >= 4) s = 3;
        else longs++;
      end
      if ($urandom_range(1, 0) == 1) inj = int'($urandom_range(5, 1));
      fire(s, $urandom_range(3, 0) == 0, inj, at);
      for (int g = 0; g < int'($urandom_range(4, 0)); g++) begin
        @(negedge clk);
        chk(int_rst === 1'b0, "R2 idle no reset", int'(int_rst), 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R2 watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule